// File: doc/BRIEF.md
# Burst Column Order Generator

This block turns one burst request into the ordered list of column addresses that a double-data-rate memory walks through during a burst. It takes three inputs: the start column, a mode-register image holding the burst length and burst type, and a single-cycle start pulse. For each beat it drives a column address together with a valid flag and a last flag. The low three column bits follow the programmed burst order. The bits above them are held at their start value for the whole burst.

Two orderings exist. Interleaved order XORs the start offset with the beat index across the whole 8-column block. Sequential order counts upward modulo 4 inside the starting 4-column half. An 8-beat sequential burst then moves to the other half and repeats the same wrap pattern there. When a start request carries a burst length code that the block does not support, the block raises an error flag and starts no burst.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `beat_valid`, `beat_last` and `mode_err` are all low.
- R2: A start pulse sampled while idle and carrying a legal length code makes the first beat visible on the next cycle. That beat's low three bits equal the start column's low three bits.
- R3: The burst length comes from mode-image bits [2:0]. Code 3'b010 gives 4 beats and code 3'b011 gives 8 beats. Beats are driven on consecutive cycles.
- R4: A start pulse sampled while idle with any other length code raises `mode_err` for exactly one cycle, one cycle after the pulse, and produces no beat.
- R5: The burst type comes from mode-image bit 3: 0 selects sequential order and 1 selects interleaved order.
- R6: In interleaved order, beat i carries offset (start XOR i) on the low three bits.
- R7: In 8-beat sequential order, bits [1:0] of beat i equal (start[1:0] + i) mod 4. Bit 2 equals start[2] for beats 0 to 3 and its inverse for beats 4 to 7.
- R8: In 4-beat bursts of either type, bit 2 keeps its start value, and bits [1:0] follow the selected order.
- R9: `beat_last` is high only on the final beat. `beat_valid` is low on the cycle after the final beat unless a new burst was accepted.
- R10: A start pulse that arrives while a burst is active, including on its final beat, is ignored. It changes neither the sequence nor the length, and it raises no error. A start on the first idle cycle after the final beat is accepted.
- R11: The column bits above bit 2 equal the start column's upper bits on every beat of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst request pulse |
| start_col | input | COL_W | Starting column address |
| mode_img | input | MR_W | Mode-register image; [2:0] length code, [3] burst type |
| beat_valid | output | 1 | A beat column is presented |
| beat_last | output | 1 | Current beat is the final one of the burst |
| beat_col | output | COL_W | Column address of the current beat |
| mode_err | output | 1 | One-cycle flag for a rejected start with an illegal length code |

## Verification
The bench builds the block with its defaults: a 10-bit column and a 13-bit mode image. The seven upper column bits can therefore carry distinctive patterns, which shows that they pass through unchanged and stay steady across a burst. The mode-image bits above bit 3 are set to nonzero junk to confirm that they are never decoded. The table covers both orderings at both lengths from start offsets in both nibbles. This exposes the nibble wrap that tells sequential order apart from a full 8-column wrap. Directed runs then place start pulses mid-burst, on the last beat and on the first idle cycle, and feed three illegal length codes.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   localparam int OFF_W     = 3;
   localparam int BEATS_MAX = 1 << OFF_W;

   localparam logic [2:0] LEN_CODE_4 = 3'b010;
   localparam logic [2:0] LEN_CODE_8 = 3'b011;

   typedef enum logic {
      ORDER_SEQ   = 1'b0,
      ORDER_INTLV = 1'b1
   } burst_order_e;

   typedef struct packed {
      logic         legal;
      logic         len8;
      burst_order_e order;
   } burst_cfg_t;

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
   import burst_seq_pkg::*;
#(
   parameter int MR_W = 13
) (
   input  logic [MR_W-1:0] mode_img,
   output burst_cfg_t      cfg
);

   localparam int LEN_LSB  = 0;
   localparam int TYPE_BIT = 3;

   generate
      if (MR_W < TYPE_BIT + 1) begin : g_bad_width
         $error("burst_cfg_decode: MR_W must cover the burst type bit");
      end
   endgenerate

   logic [2:0] len_code;

   always_comb begin
      len_code  = mode_img[LEN_LSB +: 3];
      cfg.len8  = (len_code == LEN_CODE_8);
      cfg.legal = (len_code == LEN_CODE_4) || (len_code == LEN_CODE_8);
      cfg.order = burst_order_e'(mode_img[TYPE_BIT]);
   end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
   import burst_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             load_len8,
   output logic             active,
   output logic [OFF_W-1:0] beat_idx,
   output logic             is_last
);

   localparam logic [OFF_W-1:0] FINAL_8 = OFF_W'(BEATS_MAX - 1);
   localparam logic [OFF_W-1:0] FINAL_4 = OFF_W'(BEATS_MAX / 2 - 1);

   logic len8_q;

   assign is_last = active && (beat_idx == (len8_q ? FINAL_8 : FINAL_4));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         beat_idx <= '0;
         len8_q   <= 1'b0;
      end else if (load && !active) begin
         active   <= 1'b1;
         beat_idx <= '0;
         len8_q   <= load_len8;
      end else if (active) begin
         if (is_last) begin
            active   <= 1'b0;
            beat_idx <= '0;
         end else begin
            beat_idx <= beat_idx + 1'b1;
         end
      end
   end

   // R3
   short_burst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !len8_q) |-> (beat_idx <= FINAL_4));

   // R3
   beat_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !is_last) |=> (active && beat_idx == $past(beat_idx) + 1'b1));

   // R10
   len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !is_last) |=> $stable(len8_q));

endmodule

// File: rtl/burst_order_calc.sv
module burst_order_calc
   import burst_seq_pkg::*;
(
   input  logic [OFF_W-1:0] base_off,
   input  logic [OFF_W-1:0] beat_idx,
   input  burst_order_e     order,
   output logic [OFF_W-1:0] beat_off
);

   localparam int NIB_W = OFF_W - 1;

   logic [NIB_W-1:0] nib_sum;

   assign nib_sum = base_off[NIB_W-1:0] + beat_idx[NIB_W-1:0];

   generate
      for (genvar b = 0; b < OFF_W; b++) begin : g_bit
         if (b < NIB_W) begin : g_low
            assign beat_off[b] = (order == ORDER_INTLV)
                               ? (base_off[b] ^ beat_idx[b])
                               : nib_sum[b];
         end else begin : g_nib_sel
            assign beat_off[b] = base_off[b] ^ beat_idx[b];
         end
      end
   endgenerate

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import burst_seq_pkg::*;
#(
   parameter int COL_W = 10,
   parameter int MR_W  = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic [MR_W-1:0]  mode_img,
   output logic             beat_valid,
   output logic             beat_last,
   output logic [COL_W-1:0] beat_col,
   output logic             mode_err
);

   localparam int UP_W = COL_W - OFF_W;

   generate
      if (COL_W < OFF_W) begin : g_bad_col
         $error("burst_col_seq: COL_W must be at least 3");
      end
   endgenerate

   burst_cfg_t       cfg;
   logic             accept;
   logic             active;
   logic             is_last;
   logic [OFF_W-1:0] beat_idx;
   logic [OFF_W-1:0] base_off_q;
   logic [OFF_W-1:0] beat_off;
   burst_order_e     order_q;

   burst_cfg_decode #(.MR_W(MR_W)) cfg_i (
      .mode_img (mode_img),
      .cfg      (cfg)
   );

   assign accept = start && !active && cfg.legal;

   burst_beat_ctr ctr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_len8 (cfg.len8),
      .active    (active),
      .beat_idx  (beat_idx),
      .is_last   (is_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_off_q <= '0;
         order_q    <= ORDER_SEQ;
         mode_err   <= 1'b0;
      end else begin
         mode_err <= start && !active && !cfg.legal;
         if (accept) begin
            base_off_q <= start_col[OFF_W-1:0];
            order_q    <= cfg.order;
         end
      end
   end

   burst_order_calc order_i (
      .base_off (base_off_q),
      .beat_idx (beat_idx),
      .order    (order_q),
      .beat_off (beat_off)
   );

   generate
      if (UP_W > 0) begin : g_upper
         logic [UP_W-1:0] upper_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               upper_q <= '0;
            else if (accept)
               upper_q <= start_col[COL_W-1:OFF_W];
         end
         assign beat_col = {upper_q, beat_off};

         // R11
         upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (beat_valid && !beat_last) |=> $stable(upper_q));
      end else begin : g_no_upper
         assign beat_col = beat_off;
      end
   endgenerate

   assign beat_valid = active;
   assign beat_last  = is_last;

   // R9
   last_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |-> beat_valid);

   // R9
   drop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |=> !beat_valid);

   // R4
   err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> !beat_valid);

   // R10
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && beat_valid) |=> (!mode_err && $stable(base_off_q) && $stable(order_q)));

   // R2
   first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !beat_valid && cfg.legal) |=>
         (beat_valid && beat_col[OFF_W-1:0] == $past(start_col[OFF_W-1:0])));

   // R8
   short_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_last && beat_idx < OFF_W'(3)) |=>
         $stable(beat_col[OFF_W-1]));

endmodule

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;

   localparam int COL_W = 10;
   localparam int MR_W  = 13;
   localparam int NV    = 9;

   // length code (2 = four beats, 3 = eight), type bit, start offset, expected offsets
   localparam logic [2:0] V_CODE  [NV] = '{3'd3, 3'd3, 3'd3, 3'd3, 3'd2, 3'd2, 3'd2, 3'd3, 3'd3};
   localparam logic       V_TYPE  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
   localparam logic [2:0] V_START [NV] = '{3'd5, 3'd5, 3'd0, 3'd3, 3'd6, 3'd3, 3'd1, 3'd6, 3'd2};
   localparam logic [2:0] V_EXP [NV][8] = '{
      '{3'd5, 3'd6, 3'd7, 3'd4, 3'd1, 3'd2, 3'd3, 3'd0},
      '{3'd5, 3'd4, 3'd7, 3'd6, 3'd1, 3'd0, 3'd3, 3'd2},
      '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7},
      '{3'd3, 3'd2, 3'd1, 3'd0, 3'd7, 3'd6, 3'd5, 3'd4},
      '{3'd6, 3'd7, 3'd4, 3'd5, 3'd0, 3'd0, 3'd0, 3'd0},
      '{3'd3, 3'd2, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
      '{3'd1, 3'd2, 3'd3, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
      '{3'd6, 3'd7, 3'd4, 3'd5, 3'd2, 3'd3, 3'd0, 3'd1},
      '{3'd2, 3'd3, 3'd0, 3'd1, 3'd6, 3'd7, 3'd4, 3'd5}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [COL_W-1:0] start_col = '0;
   logic [MR_W-1:0]  mode_img = '0;
   logic             beat_valid;
   logic             beat_last;
   logic [COL_W-1:0] beat_col;
   logic             mode_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   burst_col_seq #(.COL_W(COL_W), .MR_W(MR_W)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_col  (start_col),
      .mode_img   (mode_img),
      .beat_valid (beat_valid),
      .beat_last  (beat_last),
      .beat_col   (beat_col),
      .mode_err   (mode_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // called at a negedge; the request is sampled by the following posedge
   task automatic request(input logic [2:0] code, input logic bt, input logic [COL_W-1:0] col);
      start     = 1'b1;
      start_col = col;
      mode_img  = {4'b1010, 5'b10110, bt, code};
   endtask

   task automatic run_vec(input int v, input logic [COL_W-4:0] up);
      int len;
      len = (V_CODE[v] == 3'd3) ? 8 : 4;
      @(negedge clk);
      request(V_CODE[v], V_TYPE[v], {up, V_START[v]});
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < len; i++) begin
         check($sformatf("R2/R3 valid v%0d b%0d", v, i), 32'(beat_valid), 32'd1);
         if (V_TYPE[v]) check($sformatf("R6 v%0d b%0d", v, i), 32'(beat_col[2:0]), 32'(V_EXP[v][i]));
         else if (len == 8) check($sformatf("R7 v%0d b%0d", v, i), 32'(beat_col[2:0]), 32'(V_EXP[v][i]));
         else check($sformatf("R8 v%0d b%0d", v, i), 32'(beat_col[2:0]), 32'(V_EXP[v][i]));
         check($sformatf("R11 v%0d b%0d", v, i), 32'(beat_col[COL_W-1:3]), 32'(up));
         check($sformatf("R9 last v%0d b%0d", v, i), 32'(beat_last), 32'(i == len - 1));
         @(negedge clk);
      end
      check($sformatf("R9 idle after v%0d", v), 32'(beat_valid), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 valid", 32'(beat_valid), 32'd0);
      check("R1 last", 32'(beat_last), 32'd0);
      check("R1 err", 32'(mode_err), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after release", 32'(beat_valid), 32'd0);

      // R5 type bit selects the order across the table
      for (int v = 0; v < NV; v++) run_vec(v, 7'(7'h55 ^ (v * 13)));

      // R4 illegal length codes
      foreach (V_CODE[k]) begin end
      for (int c = 0; c < 3; c++) begin
         logic [2:0] bad;
         bad = (c == 0) ? 3'b000 : (c == 1) ? 3'b001 : 3'b111;
         @(negedge clk);
         request(bad, 1'b0, 10'h3a5);
         @(negedge clk);
         start = 1'b0;
         check("R4 err raised", 32'(mode_err), 32'd1);
         check("R4 no beat", 32'(beat_valid), 32'd0);
         @(negedge clk);
         check("R4 err one cycle", 32'(mode_err), 32'd0);
         check("R4 still idle", 32'(beat_valid), 32'd0);
      end

      // R10 start during burst, then on its last beat, then right after
      @(negedge clk);
      request(3'd3, 1'b0, {7'h2b, 3'd5});
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 8; i++) begin
         check("R10 seq kept", 32'(beat_col), 32'({7'h2b, V_EXP[0][i]}));
         check("R10 no err", 32'(mode_err), 32'd0);
         if (i == 2) request(3'd2, 1'b1, {7'h11, 3'd0});
         else if (i == 4) request(3'd5, 1'b1, 10'h0);
         else if (i == 7) request(3'd2, 1'b1, {7'h66, 3'd3});
         else start = 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
      check("R10 last-beat start ignored", 32'(beat_valid), 32'd0);
      check("R10 no err after ignore", 32'(mode_err), 32'd0);
      request(3'd2, 1'b1, {7'h66, 3'd3});
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 4; i++) begin
         check("R10 accepted after last", 32'(beat_col), 32'({7'h66, V_EXP[5][i]}));
         check("R9 short last", 32'(beat_last), 32'(i == 3));
         @(negedge clk);
      end
      check("R9 idle at end", 32'(beat_valid), 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule